// File: doc/BRIEF.md
# Four-Phase Dual-Rail Pulse Pipeline

This block is a cycle-accurate digital model of a two-level adiabatic shift chain. A two-bit tick counter advances once per tick event (`tick_en` high on a clock edge) and produces four overlapping phase signals. Each phase is high for two consecutive ticks, and each phase starts one tick after the phase before it.

A chain of `STAGES` stages carries dual-rail data. Stage k is gated by phase k mod 4. It captures its upstream pair on the tick event that raises its phase, holds the pair while that phase stays high, and returns to empty on the tick event that lowers it. A pulse therefore moves forward one stage per tick and is held two ticks at each stage. Any stage can swap its rails, which inverts the value and adds no delay. A flag reports any stage that holds both rails high.

Top module: `pulse_pipe`

## Requirements
- R1: A synchronous reset sets the tick counter to 0, so `phase` reads 4'b1001. All stage rails go low, so `out_t`, `out_f` and `enc_err` read 0.
- R2: Each tick event advances the counter by one, modulo 4. Phase bit i is high exactly when the counter equals i or (i+1) mod 4, so exactly two phase bits are high at any time.
- R3: On a clock edge with `tick_en` low, the counter and all stage rails keep their values.
- R4: Stage 0 samples the input pair only on the tick event that moves the counter from 3 to 0. An input pair driven at any other time has no effect on the output.
- R5: A pair present while the counter reads 3 appears at the output after exactly `STAGES` tick events. It stays there for two tick events and then the output returns to empty.
- R6: When `inv_sel[k]` is 1, stage k swaps its true and false rails. The output value is the input value XOR the parity of `inv_sel`, with no added latency.
- R7: The rail encoding is as follows. The true rail high means 1. The false rail high means 0. Both rails low means no data, and it travels through the chain as no data.
- R8: `enc_err` is high whenever any stage holds both rails high. An input with both rails high travels down the chain unchanged.
- R9: Pairs injected on every fourth tick event travel together in the chain without affecting each other. Each pair arrives intact at its own time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Tick event qualifier |
| in_t | input | 1 | Input true rail |
| in_f | input | 1 | Input false rail |
| inv_sel | input | STAGES | Per-stage rail swap select |
| phase | output | 4 | Four overlapping phase signals |
| out_t | output | 1 | Output true rail |
| out_f | output | 1 | Output false rail |
| enc_err | output | 1 | A stage holds both rails high |

## Verification
The assertions check the phase behaviour on every cycle. They check that exactly two phases are high, that the phase pattern rotates by one on each tick event, and that the phases and output rails do not move without a tick event. They also check that both output rails high always raises the error flag. The bench scenarios are needed for the rest. These are the exact arrival tick and two-tick hold of each pulse, the XOR of the value with the parity of all 64 inversion masks, the ignoring of inputs off the capture tick, streams of back-to-back pulses, and reset while pulses are in flight.

// File: rtl/pulse_pipe.sv
module pulse_pipe #(
  parameter int STAGES = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              in_t,
  input  logic              in_f,
  input  logic [STAGES-1:0] inv_sel,
  output logic [3:0]        phase,
  output logic              out_t,
  output logic              out_f,
  output logic              enc_err
);
  localparam int LAST = STAGES - 1;

  logic [1:0] tick_q;
  logic [1:0] tick_nx;
  logic [STAGES-1:0] rail_t, rail_f;

  assign tick_nx = tick_q + 2'd1;

  always_ff @(posedge clk) begin
    if (rst)          tick_q <= 2'd0;
    else if (tick_en) tick_q <= tick_nx;
  end

  for (genvar i = 0; i < 4; i++) begin : g_phase
    localparam logic [1:0] PI = 2'(i);
    localparam logic [1:0] PN = 2'((i + 1) % 4);
    assign phase[i] = (tick_q == PI) || (tick_q == PN);
  end

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam logic [1:0] RISE = 2'(k % 4);
    localparam logic [1:0] FALL = 2'((k + 2) % 4);
    logic up_t, up_f, st_t, st_f, cap, drop;

    if (k == 0) begin : g_head
      assign up_t = in_t;
      assign up_f = in_f;
    end else begin : g_body
      assign up_t = rail_t[k-1];
      assign up_f = rail_f[k-1];
    end

    assign cap  = tick_en && (tick_nx == RISE);
    assign drop = tick_en && (tick_nx == FALL);

    always_ff @(posedge clk) begin
      if (rst) begin
        st_t <= 1'b0;
        st_f <= 1'b0;
      end else if (cap) begin
        st_t <= inv_sel[k] ? up_f : up_t;
        st_f <= inv_sel[k] ? up_t : up_f;
      end else if (drop) begin
        st_t <= 1'b0;
        st_f <= 1'b0;
      end
    end

    assign rail_t[k] = st_t;
    assign rail_f[k] = st_f;
  end

  assign out_t   = rail_t[LAST];
  assign out_f   = rail_f[LAST];
  assign enc_err = |(rail_t & rail_f);
endmodule

// File: rtl/pulse_pipe_chk.sv
module pulse_pipe_chk #(
  parameter int STAGES = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_en,
  input logic [STAGES-1:0] inv_sel,
  input logic [3:0]        phase,
  input logic              out_t,
  input logic              out_f,
  input logic              enc_err
);
  a_r2_two_phases: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> $countones(phase) == 2);

  a_r2_rotate: assert property (@(posedge clk) disable iff (rst)
    tick_en |=> phase == {$past(phase[2:0]), $past(phase[3])});

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(phase) && $stable(out_t) && $stable(out_f));

  a_r8_err_out: assert property (@(posedge clk) disable iff (rst)
    (out_t && out_f) |-> enc_err);
endmodule

bind pulse_pipe pulse_pipe_chk #(.STAGES(STAGES)) chk_i (
  .clk(clk), .rst(rst), .tick_en(tick_en), .inv_sel(inv_sel),
  .phase(phase), .out_t(out_t), .out_f(out_f), .enc_err(enc_err)
);

// File: tb/pulse_pipe_tb_top.sv
`timescale 1ns/1ps
module pulse_pipe_tb_top;
  localparam int S = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0;
  logic in_t = 1'b0, in_f = 1'b0;
  logic [S-1:0] inv_sel = '0;
  logic [3:0] phase;
  logic out_t, out_f, enc_err;

  int errors = 0;
  int checks = 0;
  int bc = 0;
  logic vals [8];

  pulse_pipe #(.STAGES(S)) dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .in_t(in_t), .in_f(in_f),
    .inv_sel(inv_sel), .phase(phase), .out_t(out_t), .out_f(out_f),
    .enc_err(enc_err)
  );

  always #2 clk = ~clk;

  initial begin
    #600000;
    errors++;
    $display("FAIL R3 watchdog expired: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic [3:0] exp_phase(int c);
    logic [3:0] p;
    for (int i = 0; i < 4; i++) p[i] = (c == i) || (c == (i + 1) % 4);
    return p;
  endfunction

  task automatic check(string req, logic [6:0] act, logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) tick_en = 1'b1;
    @(negedge clk) tick_en = 1'b0;
    bc = (bc + 1) % 4;
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    bc = 0;
  endtask

  task automatic to_three();
    while (bc != 3) tick();
  endtask

  task automatic run(int np, logic [S-1:0] mask, string req);
    logic par, ev;
    logic [6:0] exp;
    int m;
    inv_sel = mask;
    par = ^mask;
    to_three();
    for (int n = 0; n < 4 * np + S + 3; n++) begin
      if (n % 4 == 0 && n / 4 < np) begin
        in_t = vals[n/4];
        in_f = ~vals[n/4];
      end
      tick();
      in_t = 1'b0;
      in_f = 1'b0;
      m = n + 1 - S;
      if (m >= 0 && m % 4 <= 1 && m / 4 < np) begin
        ev = vals[m/4] ^ par;
        exp = {exp_phase(bc), ev, ~ev, 1'b0};
      end else begin
        exp = {exp_phase(bc), 3'b000};
      end
      check(req, {phase, out_t, out_f, enc_err}, exp);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1 reset state", {phase, out_t, out_f, enc_err}, {4'b1001, 3'b000});

    for (int t = 0; t < 8; t++) begin
      tick();
      check("R2 phase pattern", {3'b000, phase}, {3'b000, exp_phase(bc)});
    end

    vals[0] = 1'b1;
    run(1, '0, "R5 latency and hold");
    vals[0] = 1'b0;
    run(1, '0, "R7 zero value");

    for (int mk = 0; mk < 64; mk++) begin
      vals[0] = mk[0] ^ mk[3];
      run(1, S'(mk), "R6 inversion parity");
    end

    for (int j = 0; j < 8; j++) vals[j] = logic'((j * 5 + 1) % 3 == 0);
    run(8, '0, "R9 stream");
    run(8, 6'b100101, "R9 stream inverted");

    to_three();
    inv_sel = '0;
    for (int t = 0; t < S + 6; t++) begin
      tick();
      check("R7 empty travels", {phase, out_t, out_f, enc_err},
            {exp_phase(bc), 3'b000});
    end

    while (bc != 0) tick();
    in_t = 1'b1;
    in_f = 1'b0;
    while (bc != 3) tick();
    in_t = 1'b0;
    for (int t = 0; t < S + 4; t++) begin
      tick();
      check("R4 off-tick input ignored", {4'b0000, out_t, out_f, enc_err}, 7'b0);
    end

    vals[0] = 1'b1;
    to_three();
    in_t = 1'b1;
    in_f = 1'b0;
    tick();
    in_t = 1'b0;
    for (int t = 1; t < S; t++) tick();
    check("R5 output arrived", {4'b0000, out_t, out_f, enc_err}, 7'b0000100);
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      check("R3 stall holds", {phase, out_t, out_f, enc_err},
            {exp_phase(bc), 3'b100});
    end
    tick();
    tick();
    check("R5 drained", {4'b0000, out_t, out_f, enc_err}, 7'b0);

    to_three();
    in_t = 1'b1;
    in_f = 1'b1;
    tick();
    in_t = 1'b0;
    in_f = 1'b0;
    check("R8 err in stage 0", {6'b0, enc_err}, 7'b1);
    for (int t = 1; t < S; t++) tick();
    check("R8 both-high at output", {4'b0000, out_t, out_f, enc_err}, 7'b0000111);
    tick();
    tick();
    check("R8 err clears", {4'b0000, out_t, out_f, enc_err}, 7'b0);

    to_three();
    in_t = 1'b1;
    in_f = 1'b0;
    tick();
    in_t = 1'b0;
    tick();
    tick();
    do_reset();
    check("R1 reset mid-flight", {phase, out_t, out_f, enc_err}, {4'b1001, 3'b000});
    for (int t = 0; t < S + 4; t++) begin
      tick();
      check("R1 flushed", {phase, out_t, out_f, enc_err}, {exp_phase(bc), 3'b000});
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule